// File: doc/BRIEF.md
# Cascadable Byte Pulse Accumulator Pair

This block holds two byte-wide counters that count rising edges on external pulse inputs. With the join control low, each counter follows its own pulse input and rolls over silently. With the join control high, the two bytes form one 16-bit accumulator. Only the low-side pulse input counts in that mode, and the upper byte steps on each carry out of the lower byte. When the joined count rolls over from 0xFFFF to 0x0000, a sticky overflow flag is raised. The flag can drive an interrupt request through an enable.

Each pulse input first passes through a synchronizer and then a rising-edge detector, so a level held high for many clocks counts once. Software can load either byte on its own through a byte write port. It can also load both bytes in the same clock through a word write port. Both bytes are always visible, separately and as one 16-bit word. A write to a byte always takes precedence over a count that lands on that byte in the same cycle. The overflow flag is cleared by a write-one strobe. A new overflow in the same cycle as a clear takes precedence over the clear.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset both counters read 0x00, the word output reads 0x0000, and the overflow flag and the interrupt request are 0.
- R2: With `join_en_i`=0, each counter adds one for each rising edge of its own pulse input and rolls over from 0xFF to 0x00 without touching the overflow flag. A level held high counts once. The count becomes visible on the third rising clock edge after the input is first sampled high.
- R3: With `join_en_i`=1, only `pulse_lo_i` advances the count. The upper byte adds one when the lower byte rolls over from 0xFF to 0x00. Edges on `pulse_hi_i` have no effect.
- R4: With `join_en_i`=1, a rollover of the upper byte from 0xFF to 0x00 sets `ovf_flag_o`. Once set, the flag stays set until it is cleared.
- R5: When a write to a byte and a counting edge for that byte fall in the same cycle, the byte takes the written value and does not count. A carry into the upper byte is produced only by a lower byte that actually counted.
- R6: A pulse on `word_wr_i` loads `word_wdata_i[15:8]` into the upper byte and `word_wdata_i[7:0]` into the lower byte in the same clock. `word_rdata_o` always shows the upper byte in bits 15:8 and the lower byte in bits 7:0. When a word write and a byte write land in the same cycle, the word write wins.
- R7: A byte write loads `byte_wdata_i` into the byte it selects and leaves the other byte unchanged.
- R8: A pulse on `ovf_clr_i` clears the overflow flag. If an overflow occurs in the same cycle, the flag stays set.
- R9: `irq_o` is high exactly when the overflow flag is high and `ovf_irq_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_lo_i | input | 1 | Asynchronous count pulse for the lower byte |
| pulse_hi_i | input | 1 | Asynchronous count pulse for the upper byte (unused when joined) |
| join_en_i | input | 1 | 1 joins the bytes into one 16-bit accumulator |
| ovf_irq_en_i | input | 1 | Interrupt enable for the overflow flag |
| byte_wr_lo_i | input | 1 | Write strobe for the lower byte |
| byte_wr_hi_i | input | 1 | Write strobe for the upper byte |
| byte_wdata_i | input | 8 | Byte write data |
| word_wr_i | input | 1 | Write strobe for both bytes at once |
| word_wdata_i | input | 16 | Word write data, upper byte in bits 15:8 |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| cnt_lo_o | output | 8 | Lower byte count |
| cnt_hi_o | output | 8 | Upper byte count |
| word_rdata_o | output | 16 | Both bytes sampled together |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a two-stage synchronizer. With 8-bit bytes, every rollover is one pulse away after a word or byte write of 0xFF or 0xFFFF, so the random mix reaches carries and overflows often. With the two-stage synchronizer, the three-cycle edge latency is short enough that the bench can place a write or a flag clear exactly in the cycle where a count lands. That is how the precedence cases are reached.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  parameter int unsigned PACC_BYTE_W = 8;
  parameter int unsigned PACC_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_JOINED = 1'b1
  } pacc_mode_e;
endpackage

// File: rtl/pacc_rst_sync.sv
module pacc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pulse_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;

  // R2: a detected edge lasts a single cycle
  assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/pacc_byte_counter.sv
module pacc_byte_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = wr_i | inc_i;
    cnt_d  = cnt_q;
    if (wr_i)       cnt_d = wdata_i;
    else if (inc_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~wr_i & (cnt_q == ALL_ONES);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cnt_q == $past(wdata_i));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + ONE);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pacc_ovf_flag.sv
module pacc_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair
  import pacc_pkg::*;
#(
  parameter int unsigned BYTE_W      = PACC_BYTE_W,
  parameter int unsigned SYNC_STAGES = PACC_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pulse_lo_i,
  input  logic                pulse_hi_i,
  input  logic                join_en_i,
  input  logic                ovf_irq_en_i,
  input  logic                byte_wr_lo_i,
  input  logic                byte_wr_hi_i,
  input  logic [BYTE_W-1:0]   byte_wdata_i,
  input  logic                word_wr_i,
  input  logic [2*BYTE_W-1:0] word_wdata_i,
  input  logic                ovf_clr_i,
  output logic [BYTE_W-1:0]   cnt_lo_o,
  output logic [BYTE_W-1:0]   cnt_hi_o,
  output logic [2*BYTE_W-1:0] word_rdata_o,
  output logic                ovf_flag_o,
  output logic                irq_o
);
  localparam int unsigned NCH = 2;
  localparam logic [BYTE_W-1:0] ONE = {{(BYTE_W-1){1'b0}}, 1'b1};

  logic             rst_sync_n;
  logic [NCH-1:0]   pulse_vec;
  logic [NCH-1:0]   edge_vec;
  pacc_mode_e       mode;
  logic             lo_wr, hi_wr, lo_wrap, hi_wrap, hi_inc, ovf_set;
  logic [BYTE_W-1:0] lo_wdata, hi_wdata;

  pacc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pulse_vec = {pulse_hi_i, pulse_lo_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
    pacc_edge_sync #(.STAGES(SYNC_STAGES)) i_edge (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pulse_i (pulse_vec[ch]),
      .edge_o  (edge_vec[ch])
    );
  end

  always_comb begin
    mode     = join_en_i ? MODE_JOINED : MODE_SPLIT;
    lo_wr    = word_wr_i | byte_wr_lo_i;
    hi_wr    = word_wr_i | byte_wr_hi_i;
    lo_wdata = word_wr_i ? word_wdata_i[BYTE_W-1:0] : byte_wdata_i;
    hi_wdata = word_wr_i ? word_wdata_i[2*BYTE_W-1:BYTE_W] : byte_wdata_i;
    hi_inc   = (mode == MODE_JOINED) ? lo_wrap : edge_vec[1];
    ovf_set  = (mode == MODE_JOINED) & hi_wrap;
  end

  pacc_byte_counter #(.W(BYTE_W)) i_cnt_lo (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc_i   (edge_vec[0]),
    .wr_i    (lo_wr),
    .wdata_i (lo_wdata),
    .cnt_o   (cnt_lo_o),
    .wrap_o  (lo_wrap)
  );

  pacc_byte_counter #(.W(BYTE_W)) i_cnt_hi (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc_i   (hi_inc),
    .wr_i    (hi_wr),
    .wdata_i (hi_wdata),
    .cnt_o   (cnt_hi_o),
    .wrap_o  (hi_wrap)
  );

  pacc_ovf_flag i_ovf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (ovf_set),
    .clr_i    (ovf_clr_i),
    .irq_en_i (ovf_irq_en_i),
    .flag_o   (ovf_flag_o),
    .irq_o    (irq_o)
  );

  assign word_rdata_o = {cnt_hi_o, cnt_lo_o};

  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (join_en_i && lo_wrap && !hi_wr) |=> cnt_hi_o == $past(cnt_hi_o) + ONE);
  assert_no_flag_split_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!join_en_i && !ovf_flag_o) |=> !ovf_flag_o);
  assert_hi_pulse_ignored_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (join_en_i && !lo_wrap && !hi_wr) |=> $stable(cnt_hi_o));
endmodule

// File: tb/test_pulse_acc_pair.sv
module test_pulse_acc_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pulse_lo, pulse_hi, join_en, ien;
  logic        bwr_lo, bwr_hi, wwr, clr;
  logic [7:0]  bdata;
  logic [15:0] wdata;
  logic [7:0]  cnt_lo, cnt_hi;
  logic [15:0] wrd;
  logic        flag, irq;

  int checks = 0;
  int errors = 0;
  logic [16:0] m_state = '0; // {flag, hi, lo}

  always #10 clk = ~clk;

  pulse_acc_pair i_pulse_acc_pair (
    .clk(clk), .rst_n(rst_n), .pulse_lo_i(pulse_lo), .pulse_hi_i(pulse_hi),
    .join_en_i(join_en), .ovf_irq_en_i(ien), .byte_wr_lo_i(bwr_lo),
    .byte_wr_hi_i(bwr_hi), .byte_wdata_i(bdata), .word_wr_i(wwr),
    .word_wdata_i(wdata), .ovf_clr_i(clr), .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .word_rdata_o(wrd), .ovf_flag_o(flag), .irq_o(irq)
  );

  function automatic logic [16:0] model_cycle(logic [16:0] s, bit casc, bit elo, bit ehi,
      bit wlo, bit whi, bit ww, logic [7:0] bd, logic [15:0] wd, bit cl);
    logic [7:0] lo, hi, nlo, nhi;
    bit lw, hw, lwrap, hinc, hwrap, f;
    lo = s[7:0]; hi = s[15:8]; f = s[16];
    lw = ww | wlo; hw = ww | whi;
    lwrap = elo & !lw & (lo == 8'hFF);
    hinc  = casc ? lwrap : ehi;
    hwrap = hinc & !hw & (hi == 8'hFF);
    nlo = lw ? (ww ? wd[7:0] : bd) : (elo ? lo + 8'd1 : lo);
    nhi = hw ? (ww ? wd[15:8] : bd) : (hinc ? hi + 8'd1 : hi);
    f = (casc & hwrap) | (f & !cl);
    return {f, nhi, nlo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " lo"},   32'(cnt_lo), 32'(m_state[7:0]));
    check({req, " hi"},   32'(cnt_hi), 32'(m_state[15:8]));
    check({req, " word"}, 32'(wrd),    32'(m_state[15:0]));
    check({req, " flag"}, 32'(flag),   32'(m_state[16]));
    check({req, " irq R9"}, 32'(irq),  32'(m_state[16] & ien));
  endtask

  // One operation: optional edges, with side actions placed in the cycle the count lands
  task automatic do_op(string req, bit elo, bit ehi, bit wlo, bit whi, bit ww,
      logic [7:0] bd, logic [15:0] wd, bit cl);
    if (elo || ehi) begin
      @(negedge clk); pulse_lo = elo; pulse_hi = ehi;
      @(negedge clk);
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    bwr_lo = wlo; bwr_hi = whi; wwr = ww; bdata = bd; wdata = wd; clr = cl;
    @(negedge clk);
    bwr_lo = 0; bwr_hi = 0; wwr = 0; clr = 0; pulse_lo = 0; pulse_hi = 0;
    m_state = model_cycle(m_state, join_en, elo, ehi, wlo, whi, ww, bd, wd, cl);
    check_all(req);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pulse_lo = 0; pulse_hi = 0; join_en = 0; ien = 0;
    bwr_lo = 0; bwr_hi = 0; wwr = 0; clr = 0; bdata = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // Separate counting
    do_op("R2 lo edge", 1, 0, 0, 0, 0, 0, 0, 0);
    do_op("R2 hi edge", 0, 1, 0, 0, 0, 0, 0, 0);
    do_op("R2 both edges", 1, 1, 0, 0, 0, 0, 0, 0);
    // Held level counts once
    @(negedge clk); pulse_lo = 1;
    repeat (12) @(negedge clk);
    pulse_lo = 0;
    m_state[7:0] = m_state[7:0] + 8'd1;
    repeat (4) @(negedge clk);
    check_all("R2 held level");
    // Byte writes and silent wraps
    do_op("R7 byte write lo", 0, 0, 1, 0, 0, 8'hFF, 0, 0);
    do_op("R2 lo wrap silent", 1, 0, 0, 0, 0, 0, 0, 0);
    do_op("R7 byte write hi", 0, 0, 0, 1, 0, 8'hFF, 0, 0);
    do_op("R2 hi wrap silent", 0, 1, 0, 0, 0, 0, 0, 0);

    // Joined mode
    @(negedge clk); join_en = 1;
    do_op("R6 word write", 0, 0, 0, 0, 1, 0, 16'h12FF, 0);
    do_op("R3 carry", 1, 0, 0, 0, 0, 0, 0, 0);
    do_op("R3 hi pulse ignored", 0, 1, 0, 0, 0, 0, 0, 0);
    do_op("R6 word write full", 0, 0, 0, 0, 1, 0, 16'hFFFF, 0);
    do_op("R4 overflow", 1, 0, 0, 0, 0, 0, 0, 0);
    check("R4 flag set", 32'(flag), 32'd1);
    @(negedge clk); ien = 1;
    @(negedge clk);
    check("R9 irq enabled", 32'(irq), 32'd1);
    do_op("R8 clear", 0, 0, 0, 0, 0, 0, 0, 1);
    check("R8 flag cleared", 32'(flag), 32'd0);
    do_op("R6 word write full 2", 0, 0, 0, 0, 1, 0, 16'hFFFF, 0);
    do_op("R8 set beats clear", 1, 0, 0, 0, 0, 0, 0, 1);
    check("R8 flag kept", 32'(flag), 32'd1);
    do_op("R8 clear 2", 0, 0, 0, 0, 0, 0, 0, 1);
    // Write beats count
    do_op("R6 setup", 0, 0, 0, 0, 1, 0, 16'h00FF, 0);
    do_op("R5 byte write beats count", 1, 0, 1, 0, 0, 8'h40, 0, 0);
    check("R5 no increment", 32'(cnt_lo), 32'h40);
    do_op("R6 setup 2", 0, 0, 0, 0, 1, 0, 16'h10FF, 0);
    do_op("R5 word write beats count", 1, 0, 0, 0, 1, 0, 16'h0055, 0);
    do_op("R6 setup 3", 0, 0, 0, 0, 1, 0, 16'h20FF, 0);
    do_op("R5 hi write vs carry", 1, 0, 0, 1, 0, 8'h77, 0, 0);
    do_op("R6 word beats byte", 0, 0, 1, 1, 1, 8'h99, 16'hABCD, 0);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [15:0] rw;
      op = $urandom_range(0, 9);
      rw = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      if (op == 0) begin
        @(negedge clk); join_en = $urandom_range(0, 1); ien = $urandom_range(0, 1);
        @(negedge clk);
        check_all("R9 mode change");
      end else if (op <= 4) begin
        do_op("R2 R3 random edges", $urandom_range(0, 1), $urandom_range(0, 1),
              0, 0, 0, 0, 0, $urandom_range(0, 3) == 0);
      end else if (op <= 6) begin
        do_op("R7 random byte write", $urandom_range(0, 1), 0,
              $urandom_range(0, 1), $urandom_range(0, 1), 0, rw[7:0], 0, 0);
      end else if (op <= 8) begin
        do_op("R6 random word write", $urandom_range(0, 1), $urandom_range(0, 1),
              0, 0, 1, 0, rw, 0);
      end else begin
        do_op("R4 R8 random clear", $urandom_range(0, 1), 0, 0, 0, 0, 0, 0, 1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd20240611);
  end
endmodule